// File: doc/BRIEF.md
# Programmable I2C Sequencing Controller

This block is a small micro-sequencer that drives an operation-level I2C master on its own, so the host processor does not have to issue each bus step itself. A fixed program, given as a parameter when the block is instantiated, is fetched one instruction at a time. Bus instructions (start, stop, byte write, byte read with or without acknowledge) become one-cycle enable pulses to the attached master, which carries out the bit timing. Non-bus instructions manage eight 8-bit scratch registers, an equality flag, conditional jumps, a millisecond wait, an addressed result port and a hold point where the host is signalled.

A typical program sets up a device index and a bus address, polls a set of devices in turn and presents each collected byte on the result port together with a one-cycle strobe. It then parks at a hold instruction until the host acknowledges, and loops. Slave acknowledge failures on writes are tallied in a saturating counter.

Top module: `i2c_seq_ctrl`

## Requirements
- R1: An instruction is 15 bits: opcode in [14:11], argument in [10:8], data in [7:0]. Instruction i of the PROGRAM parameter sits in bits [15*i+14:15*i]. After reset execution starts at instruction 0, normally advances by one, and wraps from the last instruction to instruction 0. Opcodes are 0 start, 1 stop, 2 write-register, 3 write-immediate, 4 read-ack, 5 read-nack, 6 load, 7 add, 8 compare, 9 output, 10 delay, 11 jump, 12 hold. Codes 13 to 15 only advance.
- R2: A bus instruction raises mst_en for exactly one cycle with mst_op set to 0 (start), 2 (stop), 3 (write), 4 (read with ack) or 5 (read with no-ack), holds mst_op and mst_wdata stable afterwards, and waits for mst_done before the next instruction runs. mst_done in the enable cycle itself is ignored. Write-register sends register[arg], and write-immediate sends the data field.
- R3: On completion of a read, mst_rdata is stored into register[arg].
- R4: Load sets register[arg] to the data field. Add sets register[arg] to register[arg] + data modulo 256, so adding 0xFE subtracts 2.
- R5: Compare sets the flag when register[arg] equals data and clears it otherwise. Jump takes the argument as a condition: 0 always, 1 if the flag is set, 2 if the flag is clear, any other value never. When taken, the target is data, or 0 if data is not below the program length.
- R6: Output puts register[arg] on out_data and data[3:0] on out_addr, and pulses out_strobe for one cycle.
- R7: Delay waits n = {arg, data} milliseconds, where a millisecond is CLK_FREQ_HZ/1000 clock cycles. The next instruction executes 1 + n*CLK_FREQ_HZ/1000 cycles after the delay executes. n = 0 takes one cycle.
- R8: Hold raises held in the following cycle. held stays high, with no bus enable and no strobe, until notify is seen high while held. Execution then resumes at the next instruction. notify has no effect at any other time.
- R9: ack_errs counts write completions with mst_nack high (slave did not acknowledge). It increments by one each time and saturates at 255.
- R10: Reset clears the registers, the flag, ack_errs, held, out_strobe, out_addr, out_data and mst_en, and sets the program counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mst_en | output | 1 | One-cycle start pulse to the bus master |
| mst_op | output | 3 | Bus primitive code for the master |
| mst_wdata | output | 8 | Byte to transmit on a write |
| mst_done | input | 1 | Master idle / operation finished |
| mst_rdata | input | 8 | Byte received by the master |
| mst_nack | input | 1 | Acknowledge level seen on the last write (1 = not acknowledged) |
| held | output | 1 | Sequencer parked at a hold instruction |
| notify | input | 1 | Host release for a hold |
| out_addr | output | 4 | Result slot address |
| out_data | output | 8 | Result value |
| out_strobe | output | 1 | One-cycle marker of a result update |
| ack_errs | output | 8 | Saturating count of unacknowledged writes |

## Verification
The hold release and the entry into a hold can fall in the same cycle. notify is already high when the hold instruction executes, so held rises and the release is sampled at the next edge. The bench raises notify while ordinary instructions are still running and keeps it high across the hold. It then checks that no stray result appears, that held lasts exactly one cycle and that execution continues at the next instruction. The wrap to instruction 0 and a saturated error counter meeting a new unacknowledged write are also provoked, and are judged from the bus operations and result values that follow.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  localparam int IW    = 15;
  localparam int ARG_W = 3;
  localparam int DAT_W = 8;

  // sequencer opcodes
  localparam logic [3:0] OP_START   = 4'd0;
  localparam logic [3:0] OP_STOP    = 4'd1;
  localparam logic [3:0] OP_WR_REG  = 4'd2;
  localparam logic [3:0] OP_WR_IMM  = 4'd3;
  localparam logic [3:0] OP_RD_ACK  = 4'd4;
  localparam logic [3:0] OP_RD_NACK = 4'd5;
  localparam logic [3:0] OP_LOAD    = 4'd6;
  localparam logic [3:0] OP_ADD     = 4'd7;
  localparam logic [3:0] OP_COMP    = 4'd8;
  localparam logic [3:0] OP_OUT     = 4'd9;
  localparam logic [3:0] OP_DELAY   = 4'd10;
  localparam logic [3:0] OP_JUMP    = 4'd11;
  localparam logic [3:0] OP_HOLD    = 4'd12;

  // codes understood by the attached bus master
  localparam logic [2:0] MOP_START   = 3'd0;
  localparam logic [2:0] MOP_RESTART = 3'd1;
  localparam logic [2:0] MOP_STOP    = 3'd2;
  localparam logic [2:0] MOP_WRITE   = 3'd3;
  localparam logic [2:0] MOP_RD_ACK  = 3'd4;
  localparam logic [2:0] MOP_RD_NACK = 3'd5;

  // jump conditions
  localparam logic [2:0] JC_ALWAYS = 3'd0;
  localparam logic [2:0] JC_EQ     = 3'd1;
  localparam logic [2:0] JC_NE     = 3'd2;

  typedef struct packed {
    logic [3:0]       op;
    logic [ARG_W-1:0] arg;
    logic [DAT_W-1:0] data;
  } seq_instr_t;

  function automatic logic [IW-1:0] seq_word(logic [3:0] op, logic [2:0] arg,
                                             logic [7:0] data);
    return {op, arg, data};
  endfunction

  // default program: poll six devices, two bytes each, then wait for the host
  localparam int DEF_LEN = 18;
  localparam logic [DEF_LEN*IW-1:0] DEF_PROG = {
    seq_word(OP_JUMP,    JC_ALWAYS, 8'h01),  // 17
    seq_word(OP_HOLD,    3'd0, 8'h00),       // 16
    seq_word(OP_JUMP,    JC_NE, 8'h03),      // 15
    seq_word(OP_COMP,    3'd0, 8'h06),       // 14
    seq_word(OP_ADD,     3'd1, 8'h02),       // 13
    seq_word(OP_ADD,     3'd0, 8'h01),       // 12
    seq_word(OP_DELAY,   3'd0, 8'h1E),       // 11
    seq_word(OP_OUT,     3'd3, 8'h02),       // 10
    seq_word(OP_OUT,     3'd2, 8'h01),       // 9
    seq_word(OP_OUT,     3'd0, 8'h00),       // 8
    seq_word(OP_STOP,    3'd0, 8'h00),       // 7
    seq_word(OP_RD_NACK, 3'd3, 8'h00),       // 6
    seq_word(OP_RD_ACK,  3'd2, 8'h00),       // 5
    seq_word(OP_WR_REG,  3'd1, 8'h00),       // 4
    seq_word(OP_START,   3'd0, 8'h00),       // 3
    seq_word(OP_LOAD,    3'd1, 8'hC1),       // 2
    seq_word(OP_LOAD,    3'd0, 8'h00),       // 1
    seq_word(OP_DELAY,   3'd3, 8'hE8)        // 0
  };

endpackage

// File: rtl/i2c_seq_prog_rom.sv
module i2c_seq_prog_rom #(
  parameter int LEN  = 18,
  parameter int PC_W = 5,
  parameter int IW   = 15,
  parameter logic [LEN*IW-1:0] PROGRAM = '0
) (
  input  logic [PC_W-1:0] pc,
  output logic [IW-1:0]   word
);

  logic [IW-1:0] words [LEN];

  for (genvar g = 0; g < LEN; g++) begin : g_word
    assign words[g] = PROGRAM[g*IW +: IW];
  end

  always_comb begin
    if (int'(pc) < LEN) word = words[pc];
    else                word = '0;
  end

endmodule

// File: rtl/i2c_seq_regfile.sv
module i2c_seq_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [NREG*DW-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    logic          en;
    assign en = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign flat[g*DW +: DW] = q;
  end

  assign rdata = flat[raddr*DW +: DW];

endmodule

// File: rtl/i2c_seq_ms_timer.sv
module i2c_seq_ms_timer #(
  parameter int CPM   = 50000,
  parameter int CNT_W = 11,
  localparam int PRE_W = (CPM > 1) ? $clog2(CPM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] ms_in,
  input  logic             run,
  output logic             expire
);

  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CPM - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] ms_q, ms_d;
  logic             tick;

  assign tick   = run && (pre_q == '0);
  assign expire = tick && (ms_q == CNT_W'(1));

  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    if (load) begin
      pre_d = PRE_MAX;
      ms_d  = ms_in;
    end else if (tick) begin
      pre_d = PRE_MAX;
      ms_d  = ms_q - 1'b1;
    end else if (run) begin
      pre_d = pre_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int PROG_LEN    = DEF_LEN,
  parameter logic [PROG_LEN*IW-1:0] PROGRAM = DEF_PROG,
  parameter int NREG        = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       mst_en,
  output logic [2:0] mst_op,
  output logic [7:0] mst_wdata,
  input  logic       mst_done,
  input  logic [7:0] mst_rdata,
  input  logic       mst_nack,
  output logic       held,
  input  logic       notify,
  output logic [3:0] out_addr,
  output logic [7:0] out_data,
  output logic       out_strobe,
  output logic [7:0] ack_errs
);

  localparam int CPM    = CLK_FREQ_HZ / 1000;
  localparam int PC_W   = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1;
  localparam int REG_AW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int MS_W   = ARG_W + DAT_W;

  typedef enum logic [1:0] {ST_EXEC, ST_WAIT, ST_DELAY, ST_HOLD} seq_state_e;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  // state
  seq_state_e      state_q, state_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            eq_q, eq_d;
  logic            en_q, en_d;
  logic [2:0]      mop_q, mop_d;
  logic [7:0]      wdat_q, wdat_d;
  logic            held_q, held_d;
  logic [3:0]      oaddr_q, oaddr_d;
  logic [7:0]      odata_q, odata_d;
  logic            stb_q, stb_d;
  logic [7:0]      ack_q, ack_d;

  // fetch
  logic [IW-1:0] word;
  seq_instr_t    ins;
  i2c_seq_prog_rom #(
    .LEN(PROG_LEN), .PC_W(PC_W), .IW(IW), .PROGRAM(PROGRAM)
  ) u_rom (
    .pc(pc_q), .word(word)
  );
  assign ins = seq_instr_t'(word);

  // register file
  logic             rf_we;
  logic [7:0]       rf_wdata;
  logic [7:0]       rf_rdata;
  logic [REG_AW-1:0] rf_addr;
  assign rf_addr = REG_AW'(ins.arg);

  i2c_seq_regfile #(.NREG(NREG), .DW(8)) u_rf (
    .clk(clk), .rst_n(rst_s_n),
    .we(rf_we), .waddr(rf_addr), .wdata(rf_wdata),
    .raddr(rf_addr), .rdata(rf_rdata)
  );

  // millisecond timer
  logic tmr_load, tmr_run, tmr_expire;
  i2c_seq_ms_timer #(.CPM(CPM), .CNT_W(MS_W)) u_tmr (
    .clk(clk), .rst_n(rst_s_n),
    .load(tmr_load), .ms_in({ins.arg, ins.data}),
    .run(tmr_run), .expire(tmr_expire)
  );

  // decode helpers
  logic [PC_W-1:0] pc_inc, jmp_tgt;
  logic            is_read, is_write, jmp_take, mst_fin;
  logic [2:0]      mop_sel;

  assign pc_inc   = (pc_q == PC_W'(PROG_LEN - 1)) ? '0 : pc_q + 1'b1;
  assign jmp_tgt  = (int'(ins.data) < PROG_LEN) ? PC_W'(ins.data) : '0;
  assign is_read  = (ins.op == OP_RD_ACK) || (ins.op == OP_RD_NACK);
  assign is_write = (ins.op == OP_WR_REG) || (ins.op == OP_WR_IMM);
  assign mst_fin  = (state_q == ST_WAIT) && !en_q && mst_done;
  assign jmp_take = (ins.arg == JC_ALWAYS) ||
                    ((ins.arg == JC_EQ) && eq_q) ||
                    ((ins.arg == JC_NE) && !eq_q);

  always_comb begin
    unique case (ins.op)
      OP_START:   mop_sel = MOP_START;
      OP_STOP:    mop_sel = MOP_STOP;
      OP_RD_ACK:  mop_sel = MOP_RD_ACK;
      OP_RD_NACK: mop_sel = MOP_RD_NACK;
      default:    mop_sel = MOP_WRITE;
    endcase
  end

  // next state
  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q;
    eq_d     = eq_q;
    en_d     = 1'b0;
    mop_d    = mop_q;
    wdat_d   = wdat_q;
    held_d   = held_q;
    oaddr_d  = oaddr_q;
    odata_d  = odata_q;
    stb_d    = 1'b0;
    ack_d    = ack_q;
    rf_we    = 1'b0;
    rf_wdata = ins.data;
    tmr_load = 1'b0;
    tmr_run  = 1'b0;

    unique case (state_q)
      ST_EXEC: begin
        case (ins.op)
          OP_START, OP_STOP, OP_WR_REG, OP_WR_IMM, OP_RD_ACK, OP_RD_NACK: begin
            en_d    = 1'b1;
            mop_d   = mop_sel;
            wdat_d  = (ins.op == OP_WR_REG) ? rf_rdata : ins.data;
            state_d = ST_WAIT;
          end
          OP_LOAD: begin
            rf_we = 1'b1;
            pc_d  = pc_inc;
          end
          OP_ADD: begin
            rf_we    = 1'b1;
            rf_wdata = rf_rdata + ins.data;
            pc_d     = pc_inc;
          end
          OP_COMP: begin
            eq_d = (rf_rdata == ins.data);
            pc_d = pc_inc;
          end
          OP_OUT: begin
            stb_d   = 1'b1;
            oaddr_d = ins.data[3:0];
            odata_d = rf_rdata;
            pc_d    = pc_inc;
          end
          OP_DELAY: begin
            if ({ins.arg, ins.data} == '0) begin
              pc_d = pc_inc;
            end else begin
              tmr_load = 1'b1;
              state_d  = ST_DELAY;
            end
          end
          OP_JUMP: pc_d = jmp_take ? jmp_tgt : pc_inc;
          OP_HOLD: begin
            held_d  = 1'b1;
            state_d = ST_HOLD;
          end
          default: pc_d = pc_inc;
        endcase
      end
      ST_WAIT: begin
        if (mst_fin) begin
          if (is_read) begin
            rf_we    = 1'b1;
            rf_wdata = mst_rdata;
          end
          if (is_write && mst_nack && (ack_q != 8'hFF)) ack_d = ack_q + 1'b1;
          pc_d    = pc_inc;
          state_d = ST_EXEC;
        end
      end
      ST_DELAY: begin
        tmr_run = 1'b1;
        if (tmr_expire) begin
          pc_d    = pc_inc;
          state_d = ST_EXEC;
        end
      end
      ST_HOLD: begin
        if (notify) begin
          held_d  = 1'b0;
          pc_d    = pc_inc;
          state_d = ST_EXEC;
        end
      end
      default: state_d = ST_EXEC;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_EXEC;
      pc_q    <= '0;
      eq_q    <= 1'b0;
      en_q    <= 1'b0;
      mop_q   <= '0;
      wdat_q  <= '0;
      held_q  <= 1'b0;
      oaddr_q <= '0;
      odata_q <= '0;
      stb_q   <= 1'b0;
      ack_q   <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      eq_q    <= eq_d;
      en_q    <= en_d;
      mop_q   <= mop_d;
      wdat_q  <= wdat_d;
      held_q  <= held_d;
      oaddr_q <= oaddr_d;
      odata_q <= odata_d;
      stb_q   <= stb_d;
      ack_q   <= ack_d;
    end
  end

  assign mst_en     = en_q;
  assign mst_op     = mop_q;
  assign mst_wdata  = wdat_q;
  assign held       = held_q;
  assign out_addr   = oaddr_q;
  assign out_data   = odata_q;
  assign out_strobe = stb_q;
  assign ack_errs   = ack_q;

endmodule

// File: rtl/i2c_seq_ctrl_chk.sv
module i2c_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mst_en,
  input logic [2:0] mst_op,
  input logic [7:0] mst_wdata,
  input logic       held,
  input logic       notify,
  input logic       out_strobe,
  input logic [7:0] ack_errs
);

  // R2
  en_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_en |=> !mst_en);

  // R2
  op_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_en |=> ($stable(mst_op) && $stable(mst_wdata)));

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !notify) |=> held);

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (!mst_en && !out_strobe));

  // R9
  ack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_errs != $past(ack_errs)) |-> (ack_errs == $past(ack_errs) + 8'd1));

  // R9
  ack_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_errs == 8'hFF) |=> (ack_errs == 8'hFF));

endmodule

bind i2c_seq_ctrl i2c_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .mst_op(mst_op),
  .mst_wdata(mst_wdata), .held(held), .notify(notify),
  .out_strobe(out_strobe), .ack_errs(ack_errs)
);

// File: tb/i2c_seq_ctrl_test.sv
module i2c_seq_ctrl_test;
  import i2c_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 5000;          // 5 cycles per millisecond
  localparam int CPM        = CLK_HZ / 1000;
  localparam int DLY_MS     = 2;
  localparam int LEN        = 29;

  localparam logic [LEN*IW-1:0] PROG = {
    seq_word(OP_HOLD,    3'd0, 8'h00),   // 28
    seq_word(OP_JUMP,    3'd5, 8'h1A),   // 27 never taken
    seq_word(OP_OUT,     3'd1, 8'h07),   // 26 must be skipped
    seq_word(OP_JUMP,    JC_EQ, 8'h1B),  // 25
    seq_word(OP_COMP,    3'd1, 8'hCB),   // 24
    seq_word(OP_OUT,     3'd1, 8'h03),   // 23
    seq_word(OP_ADD,     3'd1, 8'hFE),   // 22
    seq_word(OP_OUT,     3'd4, 8'h0F),   // 21
    seq_word(OP_JUMP,    JC_NE, 8'h11),  // 20
    seq_word(OP_COMP,    3'd4, 8'h00),   // 19
    seq_word(OP_ADD,     3'd4, 8'h01),   // 18
    seq_word(OP_WR_IMM,  3'd0, 8'h5A),   // 17
    seq_word(OP_LOAD,    3'd4, 8'h00),   // 16
    seq_word(OP_HOLD,    3'd0, 8'h00),   // 15
    seq_word(OP_JUMP,    JC_NE, 8'h02),  // 14
    seq_word(OP_COMP,    3'd0, 8'h06),   // 13
    seq_word(OP_ADD,     3'd1, 8'h02),   // 12
    seq_word(OP_ADD,     3'd0, 8'h01),   // 11
    seq_word(OP_DELAY,   3'd0, 8'(DLY_MS)), // 10
    seq_word(OP_OUT,     3'd3, 8'h02),   // 9
    seq_word(OP_OUT,     3'd2, 8'h01),   // 8
    seq_word(OP_OUT,     3'd0, 8'h00),   // 7
    seq_word(OP_STOP,    3'd0, 8'h00),   // 6
    seq_word(OP_RD_NACK, 3'd3, 8'h00),   // 5
    seq_word(OP_RD_ACK,  3'd2, 8'h00),   // 4
    seq_word(OP_WR_REG,  3'd1, 8'h00),   // 3
    seq_word(OP_START,   3'd0, 8'h00),   // 2
    seq_word(OP_LOAD,    3'd1, 8'hC1),   // 1
    seq_word(OP_LOAD,    3'd0, 8'h00)    // 0
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       notify = 1'b0;
  logic       mst_en, out_strobe, held;
  logic [2:0] mst_op;
  logic [7:0] mst_wdata, out_data, ack_errs;
  logic [3:0] out_addr;
  logic       m_done, m_nack;
  logic [7:0] m_rdata, m_last;
  logic [2:0] m_op;
  logic [2:0] m_cnt;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int en_n = 0;
  int s7_n = 0;

  i2c_seq_ctrl #(.CLK_FREQ_HZ(CLK_HZ), .PROG_LEN(LEN), .PROGRAM(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .mst_op(mst_op),
    .mst_wdata(mst_wdata), .mst_done(m_done), .mst_rdata(m_rdata),
    .mst_nack(m_nack), .held(held), .notify(notify), .out_addr(out_addr),
    .out_data(out_data), .out_strobe(out_strobe), .ack_errs(ack_errs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (mst_en) en_n <= en_n + 1;
    if (out_strobe && out_addr == 4'd7) s7_n <= s7_n + 1;
  end

  // bus master model: finishes 4 cycles after the enable is seen.
  // Writes whose byte has bit 1 set are not acknowledged; reads return
  // the last written byte plus 1 (ack read) or plus 2 (no-ack read).
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done <= 1'b1; m_cnt <= '0; m_nack <= 1'b0; m_rdata <= '0;
      m_last <= '0;   m_op <= '0;
    end else if (mst_en) begin
      m_done <= 1'b0; m_cnt <= 3'd3; m_op <= mst_op;
      if (mst_op == MOP_WRITE) m_last <= mst_wdata;
    end else if (m_cnt != 0) begin
      m_cnt <= m_cnt - 1'b1;
      if (m_cnt == 3'd1) begin
        m_done  <= 1'b1;
        m_nack  <= (m_op == MOP_WRITE) && m_last[1];
        m_rdata <= (m_op == MOP_RD_ACK) ? m_last + 8'd1 : m_last + 8'd2;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_en(input logic [2:0] op, input bit chkdat,
                           input logic [7:0] dat, input string tag, output int t);
    do @(negedge clk); while (!mst_en);
    t = cyc;
    chk(mst_op == op, {tag, " op"}, mst_op, op);
    if (chkdat) chk(mst_wdata == dat, {tag, " wdata"}, mst_wdata, dat);
  endtask

  task automatic expect_stb(input logic [3:0] a, input logic [7:0] d,
                            input string tag, output int t);
    do @(negedge clk); while (!out_strobe);
    t = cyc;
    chk(out_addr == a, {tag, " addr"}, out_addr, a);
    chk(out_data == d, {tag, " data"}, out_data, d);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    int t, t2, en0;
    logic [7:0] dev;
    t2 = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!held && !out_strobe && !mst_en, "R10 controls", {held, out_strobe, mst_en}, 0);
    chk(ack_errs == 8'h00 && out_data == 8'h00 && out_addr == 4'h0, "R10 values",
        ack_errs, 0);
    rst_n = 1'b1;

    // first round: six device passes
    for (int i = 0; i < 6; i++) begin
      dev = 8'hC1 + 8'(2 * i);
      expect_en(MOP_START, 1'b0, 8'h00, "R2 start", t);
      // R7 delay: output strobe to next start = 6 + n*CPM cycles
      if (i > 0) chk(t - t2 == 6 + DLY_MS * CPM, "R7 delay gap", t - t2, 6 + DLY_MS * CPM);
      expect_en(MOP_WRITE,   1'b1, dev, "R2 R4 write reg", t);
      expect_en(MOP_RD_ACK,  1'b0, 8'h00, "R2 read ack", t);
      expect_en(MOP_RD_NACK, 1'b0, 8'h00, "R2 read nack", t);
      expect_en(MOP_STOP,    1'b0, 8'h00, "R2 stop", t);
      expect_stb(4'd0, 8'(i), "R4 R6 index", t);
      expect_stb(4'd1, dev + 8'd1, "R3 ack byte", t);
      expect_stb(4'd2, dev + 8'd2, "R3 nack byte", t2);
      @(negedge clk);
      chk(!out_strobe, "R6 single strobe", out_strobe, 0);
    end

    // R5 loop exit and R8 hold
    do @(negedge clk); while (!held);
    chk(ack_errs == 8'd3, "R9 count", ack_errs, 3);
    en0 = en_n;
    repeat (30) @(negedge clk);
    chk(held, "R8 stays held", held, 1);
    chk(en_n == en0, "R8 no bus op while held", en_n - en0, 0);
    notify = 1'b1;
    @(negedge clk);
    notify = 1'b0;
    chk(!held, "R8 release", held, 0);

    // 256 unacknowledged immediate writes: saturation and add wrap
    for (int k = 0; k < 256; k++) expect_en(MOP_WRITE, 1'b1, 8'h5A, "R2 write imm", t);
    expect_stb(4'hF, 8'h00, "R4 add wrap", t);
    expect_stb(4'h3, 8'hCB, "R4 subtract", t);
    notify = 1'b1;               // raised early: ignored until the hold
    do @(negedge clk); while (!held);
    @(negedge clk);
    chk(!held, "R8 notify already high", held, 0);
    notify = 1'b0;
    chk(ack_errs == 8'hFF, "R9 saturation", ack_errs, 8'hFF);
    chk(s7_n == 0, "R5 equal jump skip", s7_n, 0);

    // R1 wrap back to instruction 0
    expect_en(MOP_START, 1'b0, 8'h00, "R1 wrap start", t);
    expect_en(MOP_WRITE, 1'b1, 8'hC1, "R1 reload", t);
    expect_en(MOP_RD_ACK, 1'b0, 8'h00, "R1 read", t);
    expect_en(MOP_RD_NACK, 1'b0, 8'h00, "R1 read", t);
    expect_en(MOP_STOP, 1'b0, 8'h00, "R1 stop", t);
    expect_stb(4'd0, 8'h00, "R1 index reload", t);
    expect_stb(4'd1, 8'hC2, "R3 ack byte", t);
    expect_stb(4'd2, 8'hC3, "R3 nack byte", t);
    chk(ack_errs == 8'hFF, "R9 held at max", ack_errs, 8'hFF);
    finish_run();
  end

endmodule